// File: doc/BRIEF.md
# Two-Wire Command Slave for a Dual Digital Potentiometer

This block is the serial front end of a dual digital potentiometer controller. It watches an oversampled two-wire bus of a clock line and a data line, both with pull-ups. It finds start and stop conditions and accepts a transaction only when the first byte carries the fixed device type code and the strapped address. It then collects an instruction byte and, for some instructions, one data byte. The slave answers through a single drive-low enable on the data line, which it uses both for acknowledges and for read data.

Decoded commands leave on a valid/ready command port toward a register executor, which holds the wiper and storage registers. Read data comes back on a one-shot response input. How many bytes a command takes depends on its opcode. A command has two bytes, three bytes, or opens an endless stream of single-step moves of the wiper. While the executor reports a nonvolatile store in progress, the slave withholds the acknowledge to the first byte. A master can therefore poll for the end of the store.

Command port rules: `cmd_valid` rises with all command fields, and both stay unchanged until a cycle with `cmd_ready` high. There is one holding slot and no clock stretching. The executor must therefore accept each command within one SCL period, or the next command overwrites it. For a read, `rsp_valid` must pulse with `rsp_data` before the SCL falling edge that ends the instruction acknowledge. The system clock must run at least 8 times the SCL rate.

Top module: `twc_cmd_slave`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. After reset, and until a start is seen, bits on the bus get no acknowledge and issue no command. A stop releases `sda_oe` in the next cycle.
- R2: The first byte after a start is acknowledged (`sda_oe` high during the ninth clock) only when bits 7:4 equal 4'b0101 and bits 3:0 equal `dev_addr`. On a mismatch the slave acknowledges nothing and issues nothing until the next start.
- R3: When `nv_busy` is high at the end of a matching first byte, that byte is not acknowledged. The same byte is acknowledged once `nv_busy` is low.
- R4: The instruction byte is laid out as opcode in bits 7:4, register select in bits 3:2, an ignored bit 1, and pot select in bit 0. These appear as `cmd_op`, `cmd_sel` and `cmd_pot`. The opcodes 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010 are acknowledged. Any other opcode gets no acknowledge and issues no command.
- R5: The read opcodes 1001 and 1011 issue their command at the end of the instruction byte. The slave then shifts out the latched `rsp_data` MSB first, changing bits after SCL falling edges. It releases the line for the master's acknowledge.
- R6: The write opcodes 1010 and 1100 take a third byte, sampled MSB first on SCL rising edges. The slave acknowledges that byte and issues one command with it in `cmd_data`.
- R7: The transfer opcodes 1101, 1110, 0001 and 1000 issue one command at the end of the instruction byte, with `cmd_data` zero.
- R8: After opcode 0010, each SCL pulse that rises and then falls issues one command with `cmd_op`=0010 and `cmd_data`={7'b0, SDA at the rising edge}, where 1 means a step up. A pulse cut short by a stop or start issues nothing.
- R9: A stop before the data byte of a write opcode is complete discards the command, and nothing is issued.
- R10: A start in any state aborts the current transaction and begins reception of a new first byte.
- R11: While `cmd_valid` is high and `cmd_ready` low, `cmd_valid` and all command fields hold steady.
- R12: `sda_oe` is only ever asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the data line is pulled low |
| dev_addr | input | 4 | Strapped device address |
| nv_busy | input | 1 | A nonvolatile store is in progress |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | The executor takes the command |
| cmd_op | output | 4 | Opcode |
| cmd_sel | output | 2 | Storage register select |
| cmd_pot | output | 1 | Potentiometer select |
| cmd_data | output | 8 | Write data or step direction |
| rsp_valid | input | 1 | Read data strobe |
| rsp_data | input | 8 | Read data from the executor |

## Verification
The hardest case to reach from the ports is the boundary between a step pulse and the end of a transaction. The SCL rising edge of a stop looks exactly like the first half of a decrement pulse. The bench sends a step stream with mixed directions and ends it with a stop. It then counts the commands, expecting exactly one per completed pulse and none for the stop. A repeated start issued midway through the instruction byte, and a stop issued three bits into a write's data byte, drive the abort paths.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_STORE = 4'b1011;
  localparam logic [3:0] OP_WR_STORE = 4'b1100;
  localparam logic [3:0] OP_LOAD_ONE = 4'b1101;
  localparam logic [3:0] OP_SAVE_ONE = 4'b1110;
  localparam logic [3:0] OP_LOAD_ALL = 4'b0001;
  localparam logic [3:0] OP_SAVE_ALL = 4'b1000;
  localparam logic [3:0] OP_STEP     = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_INSTR, ST_WDATA, ST_RDATA, ST_STEP, ST_SKIP
  } twc_state_e;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] sel;
    logic       pot;
    logic [7:0] data;
  } twc_cmd_t;
endpackage

// File: rtl/twc_line_sync.sv
module twc_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] prev
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], raw[i]};
    end
    assign lvl[i]  = chain[STAGES-1];
    assign prev[i] = chain[STAGES];
  end
endmodule

// File: rtl/twc_op_decode.sv
module twc_op_decode
  import twc_pkg::*;
(
  input  logic [3:0] op,
  output logic       legal,
  output logic       is_rd,
  output logic       is_wr,
  output logic       is_xfer,
  output logic       is_step
);
  always_comb begin
    is_rd   = 1'b0;
    is_wr   = 1'b0;
    is_xfer = 1'b0;
    is_step = 1'b0;
    case (op)
      OP_RD_WIPER, OP_RD_STORE:                         is_rd   = 1'b1;
      OP_WR_WIPER, OP_WR_STORE:                         is_wr   = 1'b1;
      OP_LOAD_ONE, OP_SAVE_ONE, OP_LOAD_ALL, OP_SAVE_ALL: is_xfer = 1'b1;
      OP_STEP:                                          is_step = 1'b1;
      default: ;
    endcase
    legal = is_rd | is_wr | is_xfer | is_step;
  end
endmodule

// File: rtl/twc_cmd_slot.sv
module twc_cmd_slot
  import twc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  twc_cmd_t push_cmd,
  input  logic     ready,
  output logic     valid,
  output twc_cmd_t cmd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      cmd   <= '0;
    end else if (push) begin
      valid <= 1'b1;
      cmd   <= push_cmd;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/twc_cmd_slave.sv
module twc_cmd_slave
  import twc_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 4,
  parameter logic [7-ADDR_W:0] TYPE_CODE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              nv_busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [3:0]        cmd_op,
  output logic [1:0]        cmd_sel,
  output logic              cmd_pot,
  output logic [7:0]        cmd_data,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data
);
  localparam int          BYTE_W   = 8;
  localparam logic [3:0]  LAST_BIT = 4'(BYTE_W);

  // line conditioning and bus events
  logic [1:0] lvl, prev;
  twc_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({sda_i, scl_i}), .lvl(lvl), .prev(prev)
  );

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
  assign scl_lvl  = lvl[0];
  assign sda_lvl  = lvl[1];
  assign scl_rise = lvl[0] & ~prev[0];
  assign scl_fall = ~lvl[0] & prev[0];
  assign start_c  = lvl[0] & prev[0] & prev[1] & ~lvl[1];
  assign stop_c   = lvl[0] & prev[0] & ~prev[1] & lvl[1];

  // transaction state
  twc_state_e      state, nxt_state;
  logic [3:0]      bit_cnt;
  logic            in_ack;
  logic [BYTE_W-1:0] sr, tx_sr, ins;
  logic            step_arm, step_dir;
  logic            push_q;
  twc_cmd_t        pcmd_q;

  // opcode classes of the byte just received
  logic dec_legal, dec_rd, dec_wr, dec_xfer, dec_step;
  twc_op_decode u_dec (
    .op(sr[7:4]), .legal(dec_legal), .is_rd(dec_rd), .is_wr(dec_wr),
    .is_xfer(dec_xfer), .is_step(dec_step)
  );

  logic rx_state, byte_end, id_eval;
  assign rx_state = (state == ST_ID) || (state == ST_INSTR) || (state == ST_WDATA);
  assign byte_end = rx_state && !in_ack && scl_fall && (bit_cnt == LAST_BIT);
  assign id_eval  = byte_end && (state == ST_ID);

  // verdict on a completed byte
  logic       ev_ok, ev_push;
  twc_state_e ev_next;
  twc_cmd_t   ev_cmd;
  always_comb begin
    ev_ok        = 1'b0;
    ev_push      = 1'b0;
    ev_next      = ST_SKIP;
    ev_cmd.op    = sr[7:4];
    ev_cmd.sel   = sr[3:2];
    ev_cmd.pot   = sr[0];
    ev_cmd.data  = '0;
    case (state)
      ST_ID: begin
        ev_ok   = (sr == {TYPE_CODE, dev_addr}) && !nv_busy;
        ev_next = ST_INSTR;
      end
      ST_INSTR: begin
        ev_ok   = dec_legal;
        ev_push = dec_rd | dec_xfer;
        if (dec_rd)        ev_next = ST_RDATA;
        else if (dec_wr)   ev_next = ST_WDATA;
        else if (dec_step) ev_next = ST_STEP;
        else               ev_next = ST_SKIP;
      end
      ST_WDATA: begin
        ev_ok       = 1'b1;
        ev_push     = 1'b1;
        ev_cmd.op   = ins[7:4];
        ev_cmd.sel  = ins[3:2];
        ev_cmd.pot  = ins[0];
        ev_cmd.data = sr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      nxt_state <= ST_IDLE;
      bit_cnt   <= '0;
      in_ack    <= 1'b0;
      sr        <= '0;
      tx_sr     <= '1;
      ins       <= '0;
      sda_oe    <= 1'b0;
      step_arm  <= 1'b0;
      step_dir  <= 1'b0;
      push_q    <= 1'b0;
      pcmd_q    <= '0;
    end else begin
      push_q <= 1'b0;
      if (start_c) begin
        state    <= ST_ID;
        bit_cnt  <= '0;
        in_ack   <= 1'b0;
        sda_oe   <= 1'b0;
        step_arm <= 1'b0;
      end else if (stop_c) begin
        state    <= ST_IDLE;
        in_ack   <= 1'b0;
        sda_oe   <= 1'b0;
        step_arm <= 1'b0;
      end else begin
        case (state)
          ST_ID, ST_INSTR, ST_WDATA: begin
            if (in_ack) begin
              if (scl_fall) begin
                in_ack  <= 1'b0;
                bit_cnt <= '0;
                state   <= nxt_state;
                sda_oe  <= (nxt_state == ST_RDATA) ? ~tx_sr[BYTE_W-1] : 1'b0;
              end
            end else if (scl_rise && bit_cnt != LAST_BIT) begin
              sr      <= {sr[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_end) begin
              if (ev_ok) begin
                in_ack    <= 1'b1;
                sda_oe    <= 1'b1;
                nxt_state <= ev_next;
                push_q    <= ev_push;
                pcmd_q    <= ev_cmd;
                if (state == ST_INSTR) ins <= sr;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise && bit_cnt != LAST_BIT) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_SKIP;
              end else begin
                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b1};
                sda_oe <= ~tx_sr[BYTE_W-2];
              end
            end
          end
          ST_STEP: begin
            if (scl_rise) begin
              step_arm <= 1'b1;
              step_dir <= sda_lvl;
            end else if (scl_fall && step_arm) begin
              step_arm    <= 1'b0;
              push_q      <= 1'b1;
              pcmd_q.op   <= ins[7:4];
              pcmd_q.sel  <= ins[3:2];
              pcmd_q.pot  <= ins[0];
              pcmd_q.data <= {{(BYTE_W-1){1'b0}}, step_dir};
            end
          end
          default: ;
        endcase
      end
      if (rsp_valid) tx_sr <= rsp_data;
    end
  end

  // command holding slot toward the executor
  twc_cmd_t slot_cmd;
  twc_cmd_slot u_slot (
    .clk(clk), .rst_n(rst_n), .push(push_q), .push_cmd(pcmd_q),
    .ready(cmd_ready), .valid(cmd_valid), .cmd(slot_cmd)
  );
  assign cmd_op   = slot_cmd.op;
  assign cmd_sel  = slot_cmd.sel;
  assign cmd_pot  = slot_cmd.pot;
  assign cmd_data = slot_cmd.data;
endmodule

// File: rtl/twc_cmd_chk.sv
module twc_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_lvl,
  input logic        sda_oe,
  input logic        stop_c,
  input logic        id_eval,
  input logic        nv_busy,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [14:0] cmd_bits
);
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe); // R1

  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (id_eval && nv_busy) |=> !sda_oe); // R3

  AST_STEP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_bits[14:11] == 4'b0010) |-> (cmd_bits[7:1] == 7'd0)); // R8

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_bits))); // R11

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl); // R12
endmodule

bind twc_cmd_slave twc_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
  .stop_c(stop_c), .id_eval(id_eval), .nv_busy(nv_busy),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_bits({cmd_op, cmd_sel, cmd_pot, cmd_data})
);

// File: tb/tb_twc_cmd_slave.sv
module tb_twc_cmd_slave;
  localparam int Q = 10;
  localparam logic [7:0] ID_OK = 8'h5A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_m, sda_m, nv_busy, cmd_ready;
  logic [3:0] dev_addr;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic [7:0] rd_value;
  logic sda_oe, cmd_valid, cmd_pot;
  logic [3:0] cmd_op;
  logic [1:0] cmd_sel;
  logic [7:0] cmd_data;
  wire sda_line = sda_m & ~sda_oe;

  twc_cmd_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_addr(dev_addr), .nv_busy(nv_busy), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_pot(cmd_pot),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // executor model: logs accepted commands, answers reads
  logic [3:0] l_op [64];
  logic [1:0] l_sel[64];
  logic       l_pot[64];
  logic [7:0] l_dat[64];
  int log_n = 0;
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (cmd_valid && cmd_ready) begin
      l_op[log_n % 64]  <= cmd_op;
      l_sel[log_n % 64] <= cmd_sel;
      l_pot[log_n % 64] <= cmd_pot;
      l_dat[log_n % 64] <= cmd_data;
      log_n <= log_n + 1;
      if (cmd_op == 4'b1001 || cmd_op == 4'b1011) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_value;
      end
    end
  end

  // drive-low seen while the bus clock is high
  logic oe_prev = 1'b0;
  int viol = 0;
  always @(posedge clk) begin
    oe_prev <= sda_oe;
    if (sda_oe && !oe_prev && scl_m) viol = viol + 1;
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask
  task automatic bstart();
    sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq(); sda_m = 1'b0; waitq(); scl_m = 1'b0; waitq();
  endtask
  task automatic bstop();
    sda_m = 1'b0; waitq(); scl_m = 1'b1; waitq(); sda_m = 1'b1; waitq(); waitq();
  endtask
  task automatic wbit(input logic b);
    sda_m = b; waitq(); scl_m = 1'b1; waitq(); waitq(); scl_m = 1'b0; waitq();
  endtask
  task automatic wbyte(input logic [7:0] v, output logic acked);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq();
    acked = (sda_line == 1'b0);
    waitq(); scl_m = 1'b0; waitq();
  endtask
  task automatic rbyte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; waitq(); scl_m = 1'b1; waitq();
      v[i] = sda_line;
      waitq(); scl_m = 1'b0; waitq();
    end
    wbit(mack);
  endtask

  task automatic t_reset();
    chk("R1", "sda_oe after reset", sda_oe, 0);
    chk("R1", "cmd_valid after reset", cmd_valid, 0);
  endtask

  task automatic t_no_start();
    logic a; int base = log_n;
    scl_m = 1'b0; waitq();
    wbyte(ID_OK, a);
    chk("R1", "ack without start", a, 0);
    wbyte(8'hD1, a);
    bstop();
    chk("R1", "commands without start", log_n - base, 0);
  endtask

  task automatic t_id();
    logic a; int base;
    bstart(); wbyte(ID_OK, a); bstop();
    chk("R2", "matching id ack", a, 1);
    bstart(); wbyte(8'h6A, a); bstop();
    chk("R2", "wrong type code ack", a, 0);
    base = log_n;
    bstart(); wbyte(8'h5B, a);
    chk("R2", "wrong address ack", a, 0);
    wbyte(8'hD1, a);
    chk("R2", "byte after mismatch ack", a, 0);
    bstop();
    chk("R2", "commands after mismatch", log_n - base, 0);
  endtask

  task automatic t_busy();
    logic a;
    nv_busy = 1'b1;
    bstart(); wbyte(ID_OK, a); bstop();
    chk("R3", "ack while busy", a, 0);
    nv_busy = 1'b0;
    bstart(); wbyte(ID_OK, a); bstop();
    chk("R3", "ack after busy", a, 1);
  endtask

  task automatic t_write(input logic [7:0] ins, input logic [7:0] d,
                         input logic [1:0] esel, input logic epot);
    logic a1, a2, a3; int base = log_n;
    bstart(); wbyte(ID_OK, a1); wbyte(ins, a2); wbyte(d, a3); bstop();
    chk("R6", "write acks", {a1, a2, a3}, 3'b111);
    chk("R6", "write command count", log_n - base, 1);
    chk("R6", "write op", l_op[base % 64], ins[7:4]);
    chk("R4", "write sel", l_sel[base % 64], esel);
    chk("R4", "write pot", l_pot[base % 64], epot);
    chk("R6", "write data", l_dat[base % 64], d);
  endtask

  task automatic t_read(input logic [7:0] ins, input logic [7:0] val);
    logic a1, a2; logic [7:0] v; int base = log_n;
    rd_value = val;
    bstart(); wbyte(ID_OK, a1); wbyte(ins, a2); rbyte(v, 1'b1); bstop();
    chk("R5", "read acks", {a1, a2}, 2'b11);
    chk("R5", "read byte", v, val);
    chk("R5", "read command count", log_n - base, 1);
    chk("R5", "read op", l_op[base % 64], ins[7:4]);
    chk("R4", "read sel/pot", {l_sel[base % 64], l_pot[base % 64]}, {ins[3:2], ins[0]});
  endtask

  task automatic t_xfer_held();
    logic a1, a2; int base = log_n;
    cmd_ready = 1'b0;
    bstart(); wbyte(ID_OK, a1); wbyte(8'b1101_01_0_1, a2);
    repeat (20) @(negedge clk);
    chk("R11", "held valid", cmd_valid, 1);
    chk("R11", "held fields", {cmd_op, cmd_sel, cmd_pot, cmd_data}, {4'hD, 2'd1, 1'b1, 8'h00});
    repeat (20) @(negedge clk);
    chk("R11", "still held", {cmd_valid, cmd_op}, {1'b1, 4'hD});
    cmd_ready = 1'b1;
    bstop();
    chk("R11", "valid dropped after accept", cmd_valid, 0);
    chk("R7", "transfer count", log_n - base, 1);
    chk("R7", "transfer op/data", {l_op[base % 64], l_dat[base % 64]}, {4'hD, 8'h00});
    base = log_n;
    bstart(); wbyte(ID_OK, a1); wbyte(8'b0001_10_0_0, a2); bstop();
    chk("R7", "global transfer ack", a2, 1);
    chk("R7", "global transfer cmd", {l_op[base % 64], l_sel[base % 64]}, {4'h1, 2'd2});
  endtask

  task automatic t_bad_op();
    logic a1, a2; int base = log_n;
    bstart(); wbyte(ID_OK, a1); wbyte(8'b0011_00_0_0, a2); bstop();
    chk("R4", "undefined opcode ack", a2, 0);
    chk("R4", "undefined opcode commands", log_n - base, 0);
  endtask

  task automatic t_step();
    logic a1, a2; int base = log_n;
    logic [3:0] dirs = 4'b1101;
    bstart(); wbyte(ID_OK, a1); wbyte(8'b0010_00_0_1, a2);
    for (int i = 3; i >= 0; i--) wbit(dirs[i]);
    bstop();
    chk("R8", "step ack", a2, 1);
    chk("R8", "step count (stop adds none)", log_n - base, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R8", "step op/pot", {l_op[(base + i) % 64], l_pot[(base + i) % 64]}, {4'h2, 1'b1});
      chk("R8", "step direction", l_dat[(base + i) % 64], {7'd0, dirs[3 - i]});
    end
  endtask

  task automatic t_stop_early();
    logic a1, a2; int base = log_n;
    bstart(); wbyte(ID_OK, a1); wbyte(8'b1010_00_0_0, a2); bstop();
    chk("R9", "stop before data byte", log_n - base, 0);
    bstart(); wbyte(ID_OK, a1); wbyte(8'b1100_00_0_1, a2);
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bstop();
    chk("R9", "stop inside data byte", log_n - base, 0);
  endtask

  task automatic t_restart();
    logic a1, a2, a3; int base = log_n;
    bstart(); wbyte(ID_OK, a1);
    wbit(1'b1); wbit(1'b1); wbit(1'b0);
    bstart();
    wbyte(ID_OK, a1); wbyte(8'b1010_00_0_0, a2); wbyte(8'h42, a3); bstop();
    chk("R10", "restart acks", {a1, a2, a3}, 3'b111);
    chk("R10", "restart command count", log_n - base, 1);
    chk("R10", "restart command", {l_op[base % 64], l_pot[base % 64], l_dat[base % 64]},
        {4'hA, 1'b0, 8'h42});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; nv_busy = 1'b0; cmd_ready = 1'b1;
    dev_addr = 4'hA; rd_value = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_no_start();
    t_id();
    t_busy();
    t_write(8'b1010_00_0_1, 8'hA5, 2'd0, 1'b1);
    t_write(8'b1100_10_0_0, 8'h3C, 2'd2, 1'b0);
    t_write(8'b1100_01_1_1, 8'h77, 2'd1, 1'b1);
    t_read(8'b1011_11_0_1, 8'hC6);
    t_read(8'b1001_00_0_0, 8'h3B);
    t_xfer_held();
    t_bad_op();
    t_step();
    t_stop_early();
    t_restart();
    chk("R12", "drive-low while SCL high", viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule